// File: doc/BRIEF.md
# CPU Clock and Standby Control

This block holds the four-bit processor clock control word and turns it into a CPU clock enable. Bits 1:0 pick how many main clock periods make one machine cycle. Bits 3:2 hold a standby request: bit 3 means STOP and bit 2 means HALT. The block produces a one-cycle `cpu_en` pulse at the chosen rate. The CPU core uses this pulse as its clock enable.

Software changes the rate with an ordinary register write. A register write never raises a standby bit. Standby is entered only through the STOP and HALT instruction strobes. A release input clears both standby bits; interrupt logic outside the block drives it.

When the CPU runs from the subsystem clock, the rate bits are ignored. In that mode the enable follows every fourth pulse of `sub_tick`, and a STOP request is refused. In HALT the prescaler keeps counting. In STOP the prescaler is frozen, and `stop_o` is raised so that it can gate the main oscillator.

Top module: `cpuclk_standby`

## Requirements
- R1: After synchronous reset the control word is all zero: `halt_o` and `stop_o` are 0, and the prescaler count is 0. The first `cpu_en` pulse comes 63 cycles after reset is released.
- R2: A write with `wr_en` loads `wr_sel` into bits 1:0 and clears both standby bits, including when the block is in standby. The one exception is a STOP or HALT strobe accepted in the same cycle, which sets its bit as usual.
- R3: A HALT strobe in a cycle with no standby bit set raises `halt_o` (bit 2) on the next cycle. While `halt_o` is 1, `cpu_en` stays 0 and the prescaler still advances by one every cycle.
- R4: A STOP strobe in a cycle with no standby bit set and with `sub_sel` = 0 raises `stop_o` (bit 3) on the next cycle. While `stop_o` is 1, the prescaler count does not change.
- R5: While `sub_sel` = 1, a STOP strobe has no effect. A HALT strobe in the same cycle is still accepted.
- R6: With `sub_sel` = 0 and no standby bit set, `cpu_en` is 1 exactly in the cycles where the prescaler count modulo P equals P-1. P is 64, 16, 8 or 4 for select codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R7: With `sub_sel` = 1 and no standby bit set, bits 1:0 are ignored. `cpu_en` is 1 in the same cycle as every fourth `sub_tick` pulse, counted from reset. The subsystem counter advances on every `sub_tick`.
- R8: When STOP and HALT strobes arrive in the same accepted cycle, only `stop_o` rises.
- R9: A STOP or HALT strobe that arrives while a standby bit is already set is ignored.
- R10: `release_i` clears both standby bits on the next cycle. When a write and a release happen in the same cycle, the new select code is loaded and both standby bits end at 0.
- R11: `halt_o` and `stop_o` are never 1 together, and `cpu_en` is 0 whenever either of them is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_sel | input | 1 | 1 while the CPU runs from the subsystem clock |
| sub_tick | input | 1 | One-cycle pulse for each subsystem clock period, already synchronised |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Clock select code written to bits 1:0 |
| stop_stb | input | 1 | STOP instruction strobe |
| halt_stb | input | 1 | HALT instruction strobe |
| release_i | input | 1 | Standby release |
| cpu_en | output | 1 | CPU clock enable pulse |
| halt_o | output | 1 | HALT mode active (bit 2) |
| stop_o | output | 1 | STOP mode active (bit 3); gates the main oscillator |

## Verification
Some rules are checked on every cycle by properties: the standby bits are mutually exclusive, the enable is gated while in standby, release clears the standby bits, strobes are ignored in standby, STOP has priority over HALT, and STOP is refused on the subsystem clock. The prescaler is checked to freeze in STOP and to advance otherwise, and the subsystem counter is checked to advance only on ticks. The actual machine-cycle lengths for each select code, the phase of the first pulse after reset, and the divide-by-four pulse spacing on the subsystem clock are shown only by the bench. It measures these gaps and compares every output against its reference model under random mixes of writes, strobes, releases and mode changes.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    // Control word: bit 3 stop, bit 2 halt, bits 1:0 clock select
    typedef struct packed {
        logic       stop;
        logic       halt;
        logic [1:0] sel;
    } ctl_word_t;

    typedef enum logic [1:0] {
        DIV_64 = 2'b00,
        DIV_16 = 2'b01,
        DIV_8  = 2'b10,
        DIV_4  = 2'b11
    } div_code_e;

    // log2 of the machine cycle length in main clock periods
    function automatic int unsigned div_log2(input logic [1:0] code);
        case (div_code_e'(code))
            DIV_64:  return 6;
            DIV_16:  return 4;
            DIV_8:   return 3;
            default: return 2;
        endcase
    endfunction

    localparam int unsigned MAX_DIV_LOG = 6;
    localparam int unsigned SUB_DIV_LOG = 2;

    function automatic logic in_standby(input ctl_word_t w);
        return w.stop | w.halt;
    endfunction

endpackage

// File: rtl/cpuclk_ctl_reg.sv
module cpuclk_ctl_reg
    import cpuclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sub_sel,
    input  logic      wr_en,
    input  logic [1:0] wr_sel,
    input  logic      stop_stb,
    input  logic      halt_stb,
    input  logic      release_i,
    output ctl_word_t ctl
);

    ctl_word_t nxt;
    logic      standby;
    logic      take_stop;
    logic      take_halt;

    always_comb begin
        standby   = in_standby(ctl);
        take_stop = !standby && stop_stb && !sub_sel;
        take_halt = !standby && halt_stb && !take_stop;
        nxt       = ctl;
        if (take_stop || take_halt) begin
            nxt.stop = take_stop;
            nxt.halt = take_halt;
        end else if (wr_en || release_i) begin
            nxt.stop = 1'b0;
            nxt.halt = 1'b0;
        end
        if (wr_en) begin
            nxt.sel = wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            ctl <= nxt;
        end
    end

    assert_mode_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.stop, ctl.halt}));

    assert_release_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (release_i && (ctl.stop || ctl.halt)) |=> (!ctl.stop && !ctl.halt));

    assert_ignore_in_standby_R9: assert property (@(posedge clk) disable iff (rst)
        ((ctl.stop || ctl.halt) && !release_i && !wr_en) |=>
            ($stable(ctl.stop) && $stable(ctl.halt)));

    assert_stop_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.stop && !ctl.halt && stop_stb && sub_sel) |=> !ctl.stop);

    assert_stop_first_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.stop && !ctl.halt && stop_stb && halt_stb && !sub_sel) |=>
            (ctl.stop && !ctl.halt));

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !stop_stb && !halt_stb) |=>
            (ctl.sel == $past(wr_sel) && !ctl.stop && !ctl.halt));

endmodule

// File: rtl/cpuclk_prescaler.sv
module cpuclk_prescaler
    import cpuclk_pkg::*;
#(
    parameter int unsigned PRE_W = MAX_DIV_LOG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic [1:0] sel,
    output logic       pulse
);

    localparam int unsigned NUM_CODES = 4;

    logic [PRE_W-1:0]     cnt;
    logic [NUM_CODES-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_tap
        localparam int unsigned L = div_log2(2'(k));
        assign tap[k] = &cnt[L-1:0];
    end

    assign pulse = tap[sel];

    assert_frozen_in_stop_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(cnt));

    assert_runs_in_halt_R3: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (cnt == $past(cnt) + PRE_W'(1)));

endmodule

// File: rtl/cpuclk_sub_div.sv
module cpuclk_sub_div
    import cpuclk_pkg::*;
#(
    parameter int unsigned DIV_LOG = SUB_DIV_LOG
) (
    input  logic clk,
    input  logic rst,
    input  logic sub_tick,
    output logic pulse
);

    logic [DIV_LOG-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sub_tick) begin
            cnt <= cnt + DIV_LOG'(1);
        end
    end

    assign pulse = sub_tick && (&cnt);

    assert_sub_step_R7: assert property (@(posedge clk) disable iff (rst)
        sub_tick |=> (cnt == $past(cnt) + DIV_LOG'(1)));

    assert_sub_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !sub_tick |=> $stable(cnt));

endmodule

// File: rtl/cpuclk_standby.sv
module cpuclk_standby
    import cpuclk_pkg::*;
#(
    parameter int unsigned PRE_W   = MAX_DIV_LOG,
    parameter int unsigned SUB_LOG = SUB_DIV_LOG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_sel,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic       stop_stb,
    input  logic       halt_stb,
    input  logic       release_i,
    output logic       cpu_en,
    output logic       halt_o,
    output logic       stop_o
);

    ctl_word_t ctl;
    logic      main_pulse;
    logic      sub_pulse;

    cpuclk_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sub_sel   (sub_sel),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .stop_stb  (stop_stb),
        .halt_stb  (halt_stb),
        .release_i (release_i),
        .ctl       (ctl)
    );

    cpuclk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .hold  (ctl.stop),
        .sel   (ctl.sel),
        .pulse (main_pulse)
    );

    cpuclk_sub_div #(.DIV_LOG(SUB_LOG)) u_sub (
        .clk      (clk),
        .rst      (rst),
        .sub_tick (sub_tick),
        .pulse    (sub_pulse)
    );

    always_comb begin
        cpu_en = 1'b0;
        if (!in_standby(ctl)) begin
            cpu_en = sub_sel ? sub_pulse : main_pulse;
        end
    end

    assign halt_o = ctl.halt;
    assign stop_o = ctl.stop;

    assert_gated_standby_R11: assert property (@(posedge clk) disable iff (rst)
        (halt_o || stop_o) |-> !cpu_en);

    assert_sub_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (sub_sel && !sub_tick) |-> !cpu_en);

endmodule

// File: tb/cpuclk_standby_test.sv
module cpuclk_standby_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_sel = 1'b0, sub_tick = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic       stop_stb = 1'b0, halt_stb = 1'b0, release_i = 1'b0;
    logic       cpu_en, halt_o, stop_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic mode_sub = 1'b0;

    // reference model state
    logic        m_stop = 1'b0, m_halt = 1'b0;
    logic [1:0]  m_sel = 2'b00;
    int unsigned mcnt = 0, scnt = 0;

    always #5 clk = ~clk;

    cpuclk_standby uut (
        .clk(clk), .rst(rst), .sub_sel(sub_sel), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .stop_stb(stop_stb),
        .halt_stb(halt_stb), .release_i(release_i),
        .cpu_en(cpu_en), .halt_o(halt_o), .stop_o(stop_o)
    );

    function automatic int unsigned period_of(input logic [1:0] c);
        case (c)
            2'b00:   return 64;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stop <= 1'b0; m_halt <= 1'b0; m_sel <= 2'b00;
            mcnt <= 0; scnt <= 0;
        end else begin
            logic sb, ts, th;
            sb = m_stop | m_halt;
            ts = !sb && stop_stb && !sub_sel;
            th = !sb && halt_stb && !ts;
            if (ts || th) begin
                m_stop <= ts; m_halt <= th;
            end else if (wr_en || release_i) begin
                m_stop <= 1'b0; m_halt <= 1'b0;
            end
            if (wr_en) m_sel <= wr_sel;
            if (!m_stop) mcnt <= mcnt + 1;
            if (sub_tick) scnt <= scnt + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        logic sb, e_en;
        int unsigned p;
        sb = m_stop | m_halt;
        p  = period_of(m_sel);
        if (sub_sel) e_en = !sb && sub_tick && ((scnt % 4) == 3);
        else         e_en = !sb && ((mcnt % p) == p - 1);
        check(cpu_en === e_en, sub_sel ? "R7 cpu_en" : (sb ? "R11 cpu_en" : "R6 cpu_en"),
              int'(cpu_en), int'(e_en));
        check(halt_o === m_halt, "R3 halt_o", int'(halt_o), int'(m_halt));
        check(stop_o === m_stop, "R4 stop_o", int'(stop_o), int'(m_stop));
    endtask

    task automatic step(input logic w, input logic [1:0] ws, input logic s,
                        input logic h, input logic r, input logic t);
        @(negedge clk);
        rst = 1'b0; sub_sel = mode_sub; wr_en = w; wr_sel = ws;
        stop_stb = s; halt_stb = h; release_i = r; sub_tick = t;
        #1;
        compare_model();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 0, 0);
    endtask

    task automatic measure_gap(output int gap);
        int guard;
        guard = 0;
        step(0, 2'b00, 0, 0, 0, 0);
        while (!cpu_en && guard < 200) begin step(0, 2'b00, 0, 0, 0, 0); guard++; end
        gap = 0;
        do begin step(0, 2'b00, 0, 0, 0, 0); gap++; end
        while (!cpu_en && gap < 200);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int gap, pulses, first;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);

        // R1: reset state and phase of the first pulse
        step(0, 2'b00, 0, 0, 0, 0);
        check(!halt_o && !stop_o, "R1 reset state", int'({stop_o, halt_o}), 0);
        first = 0;
        while (!cpu_en && first < 100) begin step(0, 2'b00, 0, 0, 0, 0); first++; end
        check(first == 63, "R1 first pulse step", first, 63);

        // R2/R6: each select code sets the machine cycle length
        for (int c = 3; c >= 0; c--) begin
            step(1, 2'(c), 0, 0, 0, 0);
            measure_gap(gap);
            check(gap == int'(period_of(2'(c))), "R6 period", gap, int'(period_of(2'(c))));
        end

        // R3: halt gates the enable
        step(1, 2'b11, 0, 0, 0, 0);
        step(0, 2'b00, 0, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(halt_o == 1'b1, "R3 halt set", int'(halt_o), 1);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin step(0, 2'b00, 0, 0, 0, 0); pulses += int'(cpu_en); end
        check(pulses == 0, "R3 no enable in halt", pulses, 0);
        // R9: stop strobe ignored during halt
        step(0, 2'b00, 1, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!stop_o && halt_o, "R9 strobe in standby", int'({stop_o, halt_o}), 1);
        step(0, 2'b00, 0, 0, 1, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!halt_o, "R10 release halt", int'(halt_o), 0);

        // R4: stop sets and freezes
        step(0, 2'b00, 1, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(stop_o == 1'b1, "R4 stop set", int'(stop_o), 1);
        step(0, 2'b00, 0, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(stop_o && !halt_o, "R9 halt in stop", int'({stop_o, halt_o}), 2);
        idle(10);
        step(0, 2'b00, 0, 0, 1, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!stop_o, "R10 release stop", int'(stop_o), 0);

        // R8: simultaneous strobes
        step(0, 2'b00, 1, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(stop_o && !halt_o, "R8 stop priority", int'({stop_o, halt_o}), 2);
        step(0, 2'b00, 0, 0, 1, 0);

        // R10: write and release together while halted
        step(0, 2'b00, 0, 1, 0, 0);
        step(1, 2'b01, 0, 0, 1, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!halt_o && !stop_o, "R10 write+release", int'({stop_o, halt_o}), 0);
        measure_gap(gap);
        check(gap == 16, "R10 new select", gap, 16);

        // R2: write alone leaves halt
        step(0, 2'b00, 0, 1, 0, 0);
        step(1, 2'b11, 0, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!halt_o, "R2 write clears halt", int'(halt_o), 0);

        // R5: stop refused on subsystem clock, halt still taken
        mode_sub = 1'b1;
        step(0, 2'b00, 1, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(!stop_o, "R5 stop refused", int'(stop_o), 0);
        step(0, 2'b00, 1, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0);
        check(halt_o && !stop_o, "R5 halt accepted", int'({stop_o, halt_o}), 1);
        step(0, 2'b00, 0, 0, 1, 0);

        // R7: every fourth tick, select ignored
        pulses = 0;
        for (int i = 0; i < 120; i++) begin
            step(0, 2'b00, 0, 0, 0, (i % 3) == 0);
            pulses += int'(cpu_en);
        end
        check(pulses == 10, "R7 sub pulses", pulses, 10);
        mode_sub = 1'b0;

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic w, s, h, r, t;
            if (($urandom % 400) == 0) mode_sub = ~mode_sub;
            w = ($urandom % 40) == 0;
            s = ($urandom % 60) == 0;
            h = ($urandom % 50) == 0;
            r = ($urandom % 25) == 0;
            t = ($urandom % 3) == 0;
            step(w, 2'($urandom), s, h, r, t);
        end

        finish_run();
    end

endmodule